// File: doc/BRIEF.md
# Periodic Event Liveness Monitor

This block supervises a group of single-cycle event strobes, such as interrupt acknowledges or "task ran" pulses, that software or hardware is expected to produce at a steady rate. Each strobe marks its own sticky bit in a status vector. A free-running window timer of programmable length marks a check point at the end of every window. At each check point, every source selected by an enable mask must have marked its bit. The status vector is then emptied automatically for the next window.

Each source also has a saturating per-window event counter and a programmable ceiling. A source that fires more often than its ceiling is flagged at once, without waiting for the check point. Any detected violation raises a sticky error line, intended to drive a watchdog reset request. Two cause vectors record, per source, whether that source went missing or ran too fast.

Top module: `evt_liveness_mon`

## Requirements
- R1: While reset is asserted and in the first cycle after its release, `err_o`, `miss_o`, `burst_o` and `seen_o` are all zero and `win_end_o` is low unless the window length is 0 or 1.
- R2: `win_end_o` is high for one cycle in every `period_i` cycles. The first pulse comes in cycle `period_i`-1 after reset release. A `period_i` of 0 behaves as 1, which puts a check point on every cycle.
- R3: A pulse on `evt_i[k]` sets `seen_o[k]` from the next cycle onwards. The bit holds until the check point that ends the window.
- R4: At a check point the status vector is cleared. An event that arrives in the check-point cycle itself is counted as the first event of the new window, so its `seen_o` bit reads 1 in the next cycle.
- R5: If `en_i[k]` is high in a check-point cycle and `seen_o[k]` is 0 in that cycle, then `miss_o[k]` is set at that clock edge.
- R6: Field k of `max_cnt_i` (bits k*CNT_W upward) is the largest number of events source k may produce in one window. The event that exceeds it, while enabled, sets `burst_o[k]` at that same clock edge, even when the window has not ended.
- R7: A source whose `en_i` bit is low in a cycle cannot set its `miss_o` or `burst_o` bit in that cycle.
- R8: `err_o` is high exactly when at least one bit of `miss_o` or `burst_o` is high.
- R9: `miss_o`, `burst_o` and `err_o` are sticky: once set they stay set until reset.
- R10: The per-window event count saturates at its all-ones value. It never wraps, so a source with a ceiling below that value keeps being flagged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | NSRC | Single-cycle event strobes, one per source |
| en_i | input | NSRC | Per-source check enable |
| period_i | input | PER_W | Window length in cycles (0 treated as 1) |
| max_cnt_i | input | NSRC*CNT_W | Per-source maximum events per window, packed |
| seen_o | output | NSRC | Sticky status vector of the current window |
| win_end_o | output | 1 | High in the check-point cycle |
| miss_o | output | NSRC | Cause: enabled source absent for a whole window |
| burst_o | output | NSRC | Cause: enabled source exceeded its ceiling |
| err_o | output | 1 | Sticky error, watchdog reset request |

## Verification
The embedded properties assume that `en_i` and `max_cnt_i` are ordinary levels sampled at the clock edge. They assume no relation between events and check points: a strobe may land on the check-point cycle, on consecutive cycles, or on a disabled source. The stimulus keeps `period_i` and the masks constant inside each segment and changes them only under reset, so every window has a well-defined length. Event density is varied from silent to every cycle, so that missing, saturating and same-cycle-clear cases all occur.

// File: rtl/elm_pkg.sv
package elm_pkg;
  // saturating increment used by the per-source window counters
  function automatic logic [31:0] sat_inc32(input logic [31:0] v, input logic [31:0] lim);
    return (v >= lim) ? lim : v + 32'd1;
  endfunction
endpackage

// File: rtl/elm_window_timer.sv
module elm_window_timer #(
  parameter int PER_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PER_W-1:0] period_i,
  output logic             win_end_o
);
  logic [PER_W-1:0] tmr_q, tmr_d;
  logic [PER_W-1:0] last_idx;
  logic             wrap;

  always_comb begin
    last_idx = (period_i == '0) ? '0 : period_i - 1'b1;
    wrap     = (tmr_q >= last_idx);
    tmr_d    = wrap ? '0 : tmr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tmr_q <= '0;
    else        tmr_q <= tmr_d;
  end

  assign win_end_o = wrap;

  // after a check point the next window starts from its first cycle
  assert_restart_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (win_end_o && period_i > 1 && $stable(period_i)) |=> !win_end_o || $changed(period_i));
endmodule

// File: rtl/elm_src_lane.sv
module elm_src_lane #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             evt_i,
  input  logic             en_i,
  input  logic [CNT_W-1:0] max_i,
  input  logic             win_end_i,
  output logic             seen_o,
  output logic             miss_o,
  output logic             burst_o,
  output logic             hit_o
);
  import elm_pkg::*;
  localparam logic [CNT_W-1:0] CNT_TOP = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q, cnt_d, base;
  logic             seen_q, seen_d;
  logic             miss_q, miss_d, burst_q, burst_d;
  logic             miss_det, burst_det;
  logic [31:0]      inc32;

  always_comb begin
    // an event on the check-point cycle belongs to the new window
    base      = win_end_i ? '0 : cnt_q;
    miss_det  = win_end_i && en_i && !seen_q;
    burst_det = evt_i && en_i && (base >= max_i);
    inc32     = sat_inc32(32'(base), 32'(CNT_TOP));
    cnt_d     = evt_i ? inc32[CNT_W-1:0] : base;
    seen_d    = win_end_i ? evt_i : (seen_q | evt_i);
    miss_d    = miss_q | miss_det;
    burst_d   = burst_q | burst_det;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      seen_q  <= 1'b0;
      miss_q  <= 1'b0;
      burst_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      seen_q  <= seen_d;
      miss_q  <= miss_d;
      burst_q <= burst_d;
    end
  end

  assign seen_o  = seen_q;
  assign miss_o  = miss_q;
  assign burst_o = burst_q;
  assign hit_o   = miss_det | burst_det;

  assert_seen_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && !win_end_i) |=> seen_q);
  assert_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (win_end_i && !evt_i) |=> !seen_q);
  assert_miss_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(miss_q) |-> $past(en_i && win_end_i));
  assert_burst_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(burst_q) |-> $past(en_i && evt_i));
  assert_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_q || burst_q) |=> (miss_q || burst_q));
  assert_no_wrap_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CNT_TOP && evt_i && !win_end_i) |=> cnt_q == CNT_TOP);
endmodule

// File: rtl/evt_liveness_mon.sv
module evt_liveness_mon #(
  parameter int NSRC  = 4,
  parameter int CNT_W = 4,
  parameter int PER_W = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NSRC-1:0]       evt_i,
  input  logic [NSRC-1:0]       en_i,
  input  logic [PER_W-1:0]      period_i,
  input  logic [NSRC*CNT_W-1:0] max_cnt_i,
  output logic [NSRC-1:0]       seen_o,
  output logic                  win_end_o,
  output logic [NSRC-1:0]       miss_o,
  output logic [NSRC-1:0]       burst_o,
  output logic                  err_o
);
  logic            win_end;
  logic [NSRC-1:0] hit;
  logic            err_q, err_d;

  elm_window_timer #(.PER_W(PER_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .period_i(period_i), .win_end_o(win_end)
  );

  for (genvar k = 0; k < NSRC; k++) begin : g_lane
    elm_src_lane #(.CNT_W(CNT_W)) u_lane (
      .clk      (clk),
      .rst_n    (rst_n),
      .evt_i    (evt_i[k]),
      .en_i     (en_i[k]),
      .max_i    (max_cnt_i[k*CNT_W +: CNT_W]),
      .win_end_i(win_end),
      .seen_o   (seen_o[k]),
      .miss_o   (miss_o[k]),
      .burst_o  (burst_o[k]),
      .hit_o    (hit[k])
    );
  end

  always_comb err_d = err_q | (|hit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= err_d;
  end

  assign err_o     = err_q;
  assign win_end_o = win_end;

  assert_err_match_R8: assert property (@(posedge clk) disable iff (!rst_n)
    err_o == |(miss_o | burst_o));
  assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |=> err_o);
endmodule

// File: tb/sim_evt_liveness_mon.sv
module sim_evt_liveness_mon;
  localparam int NSRC = 4;
  localparam int CNT_W = 4;
  localparam int PER_W = 16;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_TOP = (1 << CNT_W) - 1;

  logic clk = 1'b0;
  logic rst_n;
  logic [NSRC-1:0] evt, en;
  logic [PER_W-1:0] period;
  logic [CNT_W-1:0] maxc [NSRC];
  logic [NSRC*CNT_W-1:0] max_flat;
  logic [NSRC-1:0] seen_o, miss_o, burst_o;
  logic win_end_o, err_o;

  int vectors = 0;
  int fails = 0;

  // reference state
  int m_tmr;
  int m_cnt [NSRC];
  logic [NSRC-1:0] m_seen, m_miss, m_burst;

  always #(CLK_PERIOD/2) clk = ~clk;

  always_comb for (int k = 0; k < NSRC; k++) max_flat[k*CNT_W +: CNT_W] = maxc[k];

  evt_liveness_mon #(.NSRC(NSRC), .CNT_W(CNT_W), .PER_W(PER_W)) u0 (
    .clk(clk), .rst_n(rst_n), .evt_i(evt), .en_i(en), .period_i(period),
    .max_cnt_i(max_flat), .seen_o(seen_o), .win_end_o(win_end_o),
    .miss_o(miss_o), .burst_o(burst_o), .err_o(err_o)
  );

  function automatic logic exp_we();
    int p1;
    p1 = (period == 0) ? 1 : int'(period);
    return m_tmr >= p1 - 1;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_tmr = 0; m_seen = '0; m_miss = '0; m_burst = '0;
      for (int k = 0; k < NSRC; k++) m_cnt[k] = 0;
    end else begin
      logic we;
      we = exp_we();
      for (int k = 0; k < NSRC; k++) begin
        int b;
        b = we ? 0 : m_cnt[k];
        if (en[k] && evt[k] && b >= int'(maxc[k])) m_burst[k] = 1'b1;
        if (we && en[k] && !m_seen[k]) m_miss[k] = 1'b1;
        m_cnt[k] = evt[k] ? ((b >= CNT_TOP) ? CNT_TOP : b + 1) : b;
        m_seen[k] = we ? evt[k] : (m_seen[k] | evt[k]);
      end
      m_tmr = we ? 0 : m_tmr + 1;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk("R2 win_end", 32'(win_end_o), 32'(exp_we()));
    chk("R3/R4 seen", 32'(seen_o), 32'(m_seen));
    chk("R5/R7 miss", 32'(miss_o), 32'(m_miss));
    chk("R6/R10 burst", 32'(burst_o), 32'(m_burst));
    chk("R8/R9 err", 32'(err_o), 32'(|(m_miss | m_burst)));
  endtask

  // advance one cycle: inputs already set, compare at the next falling edge
  task automatic tick();
    @(negedge clk);
    compare_all();
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    evt = '0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog R2 actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 1'b0; evt = '0; en = '0; period = 16'd4;
    for (int k = 0; k < NSRC; k++) maxc[k] = 4'd3;
    do_reset();
    // R1: quiet outputs straight after release
    chk("R1 err", 32'(err_o), 0);
    chk("R1 miss", 32'(miss_o), 0);
    chk("R1 burst", 32'(burst_o), 0);
    chk("R1 seen", 32'(seen_o), 0);
    chk("R1 win_end", 32'(win_end_o), 0);

    // R5 and R7: silent sources, src3 masked, period 4
    en = 4'b0111; period = 16'd4;
    do_reset();
    for (int c = 0; c < 3; c++) begin
      chk("R2 no early check point", 32'(win_end_o), 0);
      tick();
    end
    chk("R2 first check point in cycle 3", 32'(win_end_o), 1);
    tick();
    chk("R5 missing enabled sources", 32'(miss_o), 32'h7);
    chk("R7 masked source clean", 32'(miss_o[3]), 0);
    chk("R8 error raised", 32'(err_o), 1);

    // R4: event on the check-point cycle goes into the new window
    en = 4'b0001; period = 16'd6;
    do_reset();
    while (!win_end_o) begin evt = 4'b0001; tick(); end
    evt = 4'b0001;
    tick();
    evt = '0;
    chk("R4 same-cycle event kept", 32'(seen_o[0]), 1);
    for (int c = 0; c < 5; c++) tick();
    chk("R4 no miss after carried event", 32'(miss_o[0]), 0);

    // R6: ceiling 1, two quick events flag immediately
    en = 4'b0010; period = 16'd40; maxc[1] = 4'd1;
    do_reset();
    tick();
    evt = 4'b0010; tick();
    chk("R6 within ceiling", 32'(burst_o[1]), 0);
    tick();
    evt = '0;
    chk("R6 immediate burst", 32'(burst_o[1]), 1);
    chk("R6 before window end", 32'(m_tmr < 39), 1);

    // R10: ceiling at all-ones, continuous events for a long window
    en = 4'b0100; period = 16'd30; maxc[2] = 4'(CNT_TOP);
    do_reset();
    evt = 4'b0100;
    for (int c = 0; c < 20; c++) tick();
    evt = '0;
    chk("R10 saturated source flagged", 32'(burst_o[2]), 1);

    // R2: period 0 acts as 1
    en = '0; period = '0;
    do_reset();
    for (int c = 0; c < 4; c++) begin
      chk("R2 period zero", 32'(win_end_o), 1);
      tick();
    end

    // random segments
    for (int s = 0; s < 60; s++) begin
      int p;
      p = (s % 3 == 0) ? 5 : ((s % 3 == 1) ? 40 : 95);
      period = 16'($urandom_range(0, 14));
      en = 4'($urandom);
      for (int k = 0; k < NSRC; k++) maxc[k] = 4'($urandom_range(0, 4));
      do_reset();
      for (int c = 0; c < 150; c++) begin
        for (int k = 0; k < NSRC; k++) evt[k] = ($urandom_range(0, 99) < p);
        tick();
      end
      evt = '0;
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule